// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This unit sits beside the integer datapath of a small processor and performs bit-level operations on 32-bit operands. It can count the zeros that lead or trail the first set bit, count the ones, mirror the word end to end, force one chosen bit low or high, and deposit a field of low-order bits at a chosen position. The operands and a 3-bit operation code arrive on a valid/ready input. The result leaves on a valid/ready output from a single register stage.

If the consumer holds `out_ready` high, the unit accepts one operation every cycle. Each result appears on the cycle after it was accepted. If the consumer drops `out_ready` while a result is waiting, that result stays frozen on the output and `in_ready` falls. No new operation is taken until the waiting result has been consumed. Instruction decode, register-file access and exception handling belong to the surrounding core.

Top module: `bmu_unit`

## Requirements
- R1: Code 3'b000 returns the number of zero bits above the highest set bit of `in_a`, or 32 when `in_a` is zero.
- R2: Code 3'b001 returns the number of zero bits below the lowest set bit of `in_a`, or 32 when `in_a` is zero.
- R3: Code 3'b010 returns the number of one bits in `in_a`.
- R4: Code 3'b011 returns `in_a` mirrored, so that bit i of the input appears at bit 31-i of the result.
- R5: Codes 3'b100 (clear) and 3'b101 (set) force the bit of `in_a` indexed by `in_b[4:0]` to 0 or to 1. All other bits pass through unchanged, and `in_b[31:5]` has no effect.
- R6: Code 3'b110 reads a length L from `in_b[12:8]` and a position P from `in_b[4:0]`. It copies `in_a[L-1:0]` into result bits starting at P, and keeps every other bit of `in_a`. L = 0 returns `in_a` unchanged. Field bits that would land above bit 31 are dropped, and the other bits of `in_b` are ignored.
- R7: Code 3'b111 returns zero.
- R8: An operation accepted at a rising edge (`in_valid` and `in_ready` both high) appears on `out_result` with `out_valid` high after that edge. An edge with `in_ready` high and `in_valid` low leaves `out_valid` low.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_result` hold their values across the edge.
- R10: A rising edge with `rst_n` low clears `out_valid`, and `in_ready` is high while the output is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the input |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | First operand (data) |
| in_b | input | 32 | Second operand (index, length and position) |
| out_valid | output | 1 | Result present on the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |

## Verification
The properties assume a sensible producer and consumer. The producer holds `in_valid` and `in_op` at known values whenever reset is released. `out_ready` is never X. Reset is asserted before the first clock edge. The bench drives every input on the falling edge and keeps `rst_n` low for several edges at the start. It holds a stalled operation steady until `in_ready` returns, so every compared result belongs to exactly one accepted operation.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int unsigned OP_W = 3;

  // Fields inside the second operand used by the field-deposit operation.
  localparam int unsigned LEN_LSB = 8;
  localparam int unsigned POS_LSB = 0;

  typedef enum logic [OP_W-1:0] {
    OP_LZCNT  = 3'b000,
    OP_TZCNT  = 3'b001,
    OP_ONES   = 3'b010,
    OP_MIRROR = 3'b011,
    OP_BITCLR = 3'b100,
    OP_BITSET = 3'b101,
    OP_DEPOSIT = 3'b110,
    OP_NULL   = 3'b111
  } bmu_op_e;
endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CNT_W = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0]  src,
  output logic [CNT_W-1:0] lead_zeros,
  output logic [CNT_W-1:0] trail_zeros,
  output logic [CNT_W-1:0] ones
);
  // Leading zeros: scanning upward, the last set bit seen is the highest one.
  always_comb begin
    lead_zeros = CNT_W'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (src[i]) lead_zeros = CNT_W'(XLEN - 1 - i);
    end
  end

  // Trailing zeros: scanning downward, the last set bit seen is the lowest one.
  always_comb begin
    trail_zeros = CNT_W'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (src[i]) trail_zeros = CNT_W'(i);
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < XLEN; i++) begin
      ones = ones + CNT_W'(src[i]);
    end
  end
endmodule

// File: rtl/bmu_mirror.sv
module bmu_mirror #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] dst
);
  for (genvar g = 0; g < XLEN; g++) begin : g_swap
    assign dst[g] = src[XLEN-1-g];
  end
endmodule

// File: rtl/bmu_insert.sv
module bmu_insert #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned IDX_W = $clog2(XLEN),
  localparam int unsigned W2 = 2 * XLEN
) (
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] ctl,
  output logic [XLEN-1:0] cleared,
  output logic [XLEN-1:0] setted,
  output logic [XLEN-1:0] deposited
);
  import bmu_pkg::*;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] flen;
  logic [IDX_W-1:0] fpos;
  logic [XLEN-1:0]  onehot;
  logic [W2-1:0]    low_mask;
  logic [W2-1:0]    wide_mask;
  logic [W2-1:0]    wide_field;
  logic             unused_ctl;

  assign idx  = ctl[IDX_W-1:0];
  assign flen = ctl[LEN_LSB +: IDX_W];
  assign fpos = ctl[POS_LSB +: IDX_W];
  assign unused_ctl = ^{ctl[XLEN-1:LEN_LSB+IDX_W], ctl[LEN_LSB-1:IDX_W]};

  assign onehot  = XLEN'(1) << idx;
  assign cleared = src & ~onehot;
  assign setted  = src | onehot;

  // Computed at double width so that field bits past the top fall away on truncation.
  assign low_mask   = (W2'(1) << flen) - W2'(1);
  assign wide_mask  = low_mask << fpos;
  assign wide_field = (W2'(src) & low_mask) << fpos;
  assign deposited  = (src & ~wide_mask[XLEN-1:0]) | (wide_field[XLEN-1:0] & wide_mask[XLEN-1:0]);
endmodule

// File: rtl/bmu_unit.sv
module bmu_unit #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CNT_W = $clog2(XLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result
);
  import bmu_pkg::*;

  logic [CNT_W-1:0] lz, tz, pc;
  logic [XLEN-1:0]  mir, clr, set, dep;
  logic [XLEN-1:0]  res_d;
  logic [XLEN-1:0]  res_q;
  logic             vld_q;

  bmu_count #(.XLEN(XLEN)) u_count (
    .src(in_a), .lead_zeros(lz), .trail_zeros(tz), .ones(pc)
  );

  bmu_mirror #(.XLEN(XLEN)) u_mirror (
    .src(in_a), .dst(mir)
  );

  bmu_insert #(.XLEN(XLEN)) u_insert (
    .src(in_a), .ctl(in_b), .cleared(clr), .setted(set), .deposited(dep)
  );

  always_comb begin
    unique case (bmu_op_e'(in_op))
      OP_LZCNT:   res_d = XLEN'(lz);
      OP_TZCNT:   res_d = XLEN'(tz);
      OP_ONES:    res_d = XLEN'(pc);
      OP_MIRROR:  res_d = mir;
      OP_BITCLR:  res_d = clr;
      OP_BITSET:  res_d = set;
      OP_DEPOSIT: res_d = dep;
      default:    res_d = '0;
    endcase
  end

  // The stage can load when it is empty or its content leaves this cycle.
  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
endmodule

// File: rtl/bmu_unit_chk.sv
module bmu_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_op,
  input logic [XLEN-1:0] in_a,
  input logic [XLEN-1:0] in_b,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result
);
  logic take;
  assign take = in_valid && in_ready;

  // R10
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R3
  ones_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 3'b010) |=> out_result == XLEN'($countones($past(in_a))));

  // R1
  lz_allzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 3'b000 && in_a == '0) |=> out_result == XLEN'(XLEN));

  // R6
  deposit_nolen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 3'b110 && in_b[12:8] == 5'd0) |=> out_result == $past(in_a));

  // R7
  null_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 3'b111) |=> out_result == '0);
endmodule

bind bmu_unit bmu_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result)
);

// File: tb/sim_bmu_unit.sv
module sim_bmu_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_op;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmu_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] m_lz(input logic [31:0] a);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (a[i]) break;
      n++;
    end
    return 32'(n);
  endfunction

  function automatic logic [31:0] m_tz(input logic [31:0] a);
    int n = 0;
    for (int i = 0; i < 32; i++) begin
      if (a[i]) break;
      n++;
    end
    return 32'(n);
  endfunction

  function automatic logic [31:0] m_pc(input logic [31:0] a);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    return 32'(n);
  endfunction

  function automatic logic [31:0] m_rev(input logic [31:0] a);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = a[i];
    return r;
  endfunction

  function automatic logic [31:0] m_dep(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = a;
    int l = int'(b[12:8]);
    int p = int'(b[4:0]);
    for (int i = 0; i < 32; i++) begin
      if (i >= p && i < p + l) r[i] = a[i-p];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one operation at a falling edge, samples at the next falling edge.
  task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    check({tag, "/R8 valid"}, 32'(out_valid), 32'd1);
    check(tag, out_result, exp);
    in_valid = 1'b0;
  endtask

  task automatic test_reset;
    check("R10 reset valid", 32'(out_valid), 32'd0);
    check("R10 reset ready", 32'(in_ready), 32'd1);
  endtask

  task automatic test_counts;
    run_op("R1 zero", 3'b000, 32'h0, 32'h0, 32'd32);
    run_op("R1 top", 3'b000, 32'h8000_0000, 32'h0, 32'd0);
    run_op("R1 one", 3'b000, 32'h1, 32'h0, 32'd31);
    run_op("R2 zero", 3'b001, 32'h0, 32'h0, 32'd32);
    run_op("R2 top", 3'b001, 32'h8000_0000, 32'h0, 32'd31);
    run_op("R3 all", 3'b010, 32'hFFFF_FFFF, 32'h0, 32'd32);
    run_op("R3 none", 3'b010, 32'h0, 32'h0, 32'd0);
    for (int k = 0; k < 30; k++) begin
      seed = nxt(seed);
      run_op("R1 rnd", 3'b000, seed >> (k % 32), 32'h0, m_lz(seed >> (k % 32)));
      run_op("R2 rnd", 3'b001, seed << (k % 32), 32'h0, m_tz(seed << (k % 32)));
      run_op("R3 rnd", 3'b010, seed, 32'h0, m_pc(seed));
    end
  endtask

  task automatic test_mirror;
    run_op("R4 one", 3'b011, 32'h1, 32'h0, 32'h8000_0000);
    run_op("R4 pat", 3'b011, 32'h0000_00F1, 32'h0, 32'h8F00_0000);
    for (int k = 0; k < 20; k++) begin
      seed = nxt(seed);
      run_op("R4 rnd", 3'b011, seed, 32'h0, m_rev(seed));
    end
  endtask

  task automatic test_bits;
    run_op("R5 clr top", 3'b100, 32'hFFFF_FFFF, 32'd31, 32'h7FFF_FFFF);
    run_op("R5 set low", 3'b101, 32'h0, 32'd0, 32'h1);
    run_op("R5 clr upper ignored", 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFE3, 32'hFFFF_FFF7);
    run_op("R5 set upper ignored", 3'b101, 32'h0, 32'hABCD_EF0A, 32'h0000_0400);
    for (int k = 0; k < 20; k++) begin
      logic [31:0] b;
      seed = nxt(seed);
      b = nxt(seed);
      run_op("R5 clr rnd", 3'b100, seed, b, seed & ~(32'h1 << b[4:0]));
      run_op("R5 set rnd", 3'b101, seed, b, seed | (32'h1 << b[4:0]));
    end
  endtask

  task automatic test_deposit;
    run_op("R6 nolen", 3'b110, 32'hDEAD_BEEF, 32'h0000_0010, 32'hDEAD_BEEF);
    run_op("R6 basic", 3'b110, 32'h0000_000B, 32'h0000_0408, 32'h0000_0B0B);
    run_op("R6 overflow dropped", 3'b110, 32'h0000_00FF, 32'h0000_081C, 32'hF000_00FF);
    run_op("R6 other bits ignored", 3'b110, 32'h0000_000B, 32'hFFFF_E4E8, 32'h0000_0B0B);
    for (int k = 0; k < 30; k++) begin
      logic [31:0] b;
      seed = nxt(seed);
      b = nxt(seed);
      run_op("R6 rnd", 3'b110, seed, b, m_dep(seed, b));
    end
  endtask

  task automatic test_null;
    run_op("R7 null", 3'b111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic test_idle;
    @(negedge clk);
    check("R8 idle empty", 32'(out_valid), 32'd0);
  endtask

  task automatic test_stall;
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'b010; in_a = 32'h0000_00FF; in_b = 32'h0;
    @(negedge clk);
    check("R8 stall first", out_result, 32'd8);
    check("R9 ready low", 32'(in_ready), 32'd0);
    in_op = 3'b011; in_a = 32'h1;
    @(negedge clk);
    check("R9 held valid", 32'(out_valid), 32'd1);
    check("R9 held result", out_result, 32'd8);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 second after release", out_result, 32'h8000_0000);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'd0);
  endtask

  task automatic test_reset_mid;
    in_valid = 1'b1; in_op = 3'b000; in_a = 32'h1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 3'b0; in_a = '0; in_b = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_counts();
    test_mirror();
    test_bits();
    test_deposit();
    test_null();
    test_idle();
    test_stall();
    test_reset_mid();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule